// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Engine

This block is the arithmetic core of a DSP pipeline. It takes two 16-bit operands, multiplies them in a 17x17 signed multiplier, and adds or subtracts the result into one of two 40-bit accumulators through a 41-bit adder. Operands are sign- or zero-extended to 17 bits, so the same multiplier handles signed, unsigned and mixed-sign products. Fractional mode treats the operands as 1.15 values and doubles the product. Integer mode leaves the product as it is. The adder can also combine the two accumulators, or negate one of them.

Each write to an accumulator can be clamped, either to the signed 32-bit range or to the full signed 40-bit range. Each accumulator has its own clamp enable. A separate output path rounds the selected accumulator to bits 31:16, using either conventional or convergent rounding. That path can also clamp the rounded value to the signed 16-bit range. Each accumulator has an overflow flag that follows its last write, and a sticky saturation flag that stays set until it is cleared.

An operation is applied on the rising clock edge on which `opValid` is high. The accumulators and the flags are registered, so the results appear after that edge. The store value is combinational. It is derived from the current contents of the accumulator that `accSel` selects.

Top module: `mac_engine`

## Requirements
- R1: After reset, both accumulators are zero and all overflow and saturation flags are low.
- R2: The sign-mode code sets how the operands are extended. 2'b00 extends both as signed, 2'b01 extends both as unsigned, and 2'b10 extends x as signed and y as unsigned. The reserved code 2'b11 behaves as signed.
- R3: When `intMode`=1 the product is used unshifted. When `intMode`=0 (fractional) the product is doubled. In both cases it is sign-extended to 40 bits.
- R4: Opcode 0 clears the target accumulator. Opcode 1 loads it with x*y, and opcode 2 loads it with -x*y. Opcode 3 adds x*y to it, and opcode 4 subtracts x*y from it.
- R5: Opcode 5 loads x*x, and opcode 6 adds x*x. Opcode 7 loads (x-y)^2, and opcode 8 adds (x-y)^2. For these four opcodes the operands are always treated as signed, whatever the sign mode.
- R6: Opcode 9 adds the other accumulator to the target. Opcode 10 subtracts the other accumulator from the target. Opcode 11 negates the target.
- R7: `accSel` (0 = A, 1 = B) picks the target accumulator, and the other accumulator keeps its value. With `opValid` low, or with an opcode from 12 to 15, neither accumulator changes.
- R8: When the target's clamp enable is set, a write is limited to [-2^31, 2^31-1] if `satWide`=0, and to [-2^39, 2^39-1] if `satWide`=1. When the enable is clear, the result wraps modulo 2^40.
- R9: A write that is clamped sets that accumulator's sticky saturation flag. `clrSatAll` clears both sticky flags, and a clamp in the same cycle still sets its flag. `satAny` is the OR of the two sticky flags, and `ovfAny` is the OR of the two overflow flags.
- R10: An accumulator's overflow flag is high exactly when its last written value lies outside the signed 32-bit range.
- R11: `storeVal` is bits 31:16 of the selected accumulator after rounding at bit 15. With `roundConv`=1 the value is rounded half up. With `roundConv`=0 values above half round up, values below half round down, and an exact half rounds to an even bit 16.
- R12: With `satEnStore`=1, a rounded value outside the signed 16-bit range gives 16'h7FFF or 16'h8000. With `satEnStore`=0, the low 16 bits of the rounded value are passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Apply opCode on this edge |
| opCode | input | 4 | Operation code |
| accSel | input | 1 | Target accumulator (0 = A, 1 = B); also selects the store source |
| xIn | input | 16 | Operand x |
| yIn | input | 16 | Operand y |
| intMode | input | 1 | 1 = integer product, 0 = fractional product |
| signMode | input | 2 | Operand extension mode |
| roundConv | input | 1 | 1 = conventional rounding, 0 = convergent rounding |
| satEnA | input | 1 | Clamp enable for accumulator A |
| satEnB | input | 1 | Clamp enable for accumulator B |
| satEnStore | input | 1 | Clamp enable for the store value |
| satWide | input | 1 | 1 = 40-bit clamp range, 0 = 32-bit clamp range |
| clrSatAll | input | 1 | Clear both sticky saturation flags |
| accA | output | 40 | Accumulator A |
| accB | output | 40 | Accumulator B |
| storeVal | output | 16 | Rounded, optionally clamped store value |
| ovfA | output | 1 | Overflow flag of A |
| ovfB | output | 1 | Overflow flag of B |
| satA | output | 1 | Sticky saturation flag of A |
| satB | output | 1 | Sticky saturation flag of B |
| ovfAny | output | 1 | OR of both overflow flags |
| satAny | output | 1 | OR of both sticky flags |

## Verification
The assertions check several rules on every cycle. An accumulator must hold when no operation is issued or when the other accumulator is the target. A sticky flag must persist until it is cleared. A narrow-range clamped write must stay inside 32 bits. A clear opcode must give zero. A low overflow flag must agree with the guard bits.

The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent reference model. This covers the values for each sign mode and product mode, squares and differences, the wrap against the clamp, and the exact-half rounding cases.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam logic [3:0] OP_CLR   = 4'd0;
  localparam logic [3:0] OP_MPY   = 4'd1;
  localparam logic [3:0] OP_MPYN  = 4'd2;
  localparam logic [3:0] OP_MAC   = 4'd3;
  localparam logic [3:0] OP_MSC   = 4'd4;
  localparam logic [3:0] OP_SQR   = 4'd5;
  localparam logic [3:0] OP_SQRAC = 4'd6;
  localparam logic [3:0] OP_ED    = 4'd7;
  localparam logic [3:0] OP_EDAC  = 4'd8;
  localparam logic [3:0] OP_ADD   = 4'd9;
  localparam logic [3:0] OP_SUB   = 4'd10;
  localparam logic [3:0] OP_NEG   = 4'd11;

  typedef enum logic [1:0] {SRC_ZERO, SRC_PROD, SRC_OTHER, SRC_SELF} mac_src_e;

  typedef struct packed {
    logic     wrEn;
    logic     dstB;
    logic     keepAcc;
    logic     negate;
    mac_src_e src;
    logic     squareX;
    logic     useDiff;
  } mac_strobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        accSel,
  output mac_strobe_t stb
);
  always_comb begin
    stb = '{wrEn: 1'b0, dstB: accSel, keepAcc: 1'b0, negate: 1'b0,
            src: SRC_ZERO, squareX: 1'b0, useDiff: 1'b0};
    if (opValid) begin
      stb.wrEn = 1'b1;
      case (opCode)
        OP_CLR:   stb.src = SRC_ZERO;
        OP_MPY:   stb.src = SRC_PROD;
        OP_MPYN:  begin stb.src = SRC_PROD; stb.negate = 1'b1; end
        OP_MAC:   begin stb.src = SRC_PROD; stb.keepAcc = 1'b1; end
        OP_MSC:   begin stb.src = SRC_PROD; stb.keepAcc = 1'b1; stb.negate = 1'b1; end
        OP_SQR:   begin stb.src = SRC_PROD; stb.squareX = 1'b1; end
        OP_SQRAC: begin stb.src = SRC_PROD; stb.squareX = 1'b1; stb.keepAcc = 1'b1; end
        OP_ED:    begin stb.src = SRC_PROD; stb.useDiff = 1'b1; end
        OP_EDAC:  begin stb.src = SRC_PROD; stb.useDiff = 1'b1; stb.keepAcc = 1'b1; end
        OP_ADD:   begin stb.src = SRC_OTHER; stb.keepAcc = 1'b1; end
        OP_SUB:   begin stb.src = SRC_OTHER; stb.keepAcc = 1'b1; stb.negate = 1'b1; end
        OP_NEG:   begin stb.src = SRC_SELF; stb.negate = 1'b1; end
        default:  stb.wrEn = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_strobe_t       stb,
  input  logic              accSel,
  input  logic [OP_W-1:0]   xIn,
  input  logic [OP_W-1:0]   yIn,
  input  logic              intMode,
  input  logic [1:0]        signMode,
  input  logic              roundConv,
  input  logic              satEnA,
  input  logic              satEnB,
  input  logic              satEnStore,
  input  logic              satWide,
  input  logic              clrSatAll,
  output logic [ACC_W-1:0]  accA,
  output logic [ACC_W-1:0]  accB,
  output logic [OP_W-1:0]   storeVal,
  output logic [1:0]        ovfFlag,
  output logic [1:0]        satFlag
);
  localparam int MUL_W    = OP_W + 1;
  localparam int PROD_W   = 2 * MUL_W;
  localparam int NARROW_W = 2 * OP_W;
  localparam int SUM_W    = ACC_W + 1;
  localparam int QW       = ACC_W - OP_W + 1;
  localparam logic signed [SUM_W-1:0] HI_WIDE   = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO_WIDE   = ~HI_WIDE;
  localparam logic signed [SUM_W-1:0] HI_NARROW = {{(SUM_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO_NARROW = ~HI_NARROW;
  localparam logic signed [QW-1:0]    HI_STORE  = {{(QW-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
  localparam logic signed [QW-1:0]    LO_STORE  = ~HI_STORE;
  localparam logic [OP_W-1:0]         HALF      = {1'b1, {(OP_W-1){1'b0}}};

  logic [ACC_W-1:0] acc [2];
  logic signed [MUL_W-1:0]  mulA, mulB, diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  prodExt, selfExt, otherExt, operand, addend, sum, hiLim, loLim, res;
  logic satEnSel, satHit, ovfNew;
  logic [ACC_W-1:0] newVal;

  assign diff = {xIn[OP_W-1], xIn} - {yIn[OP_W-1], yIn};

  always_comb begin
    if (stb.useDiff) begin
      mulA = diff; mulB = diff;
    end else if (stb.squareX) begin
      mulA = {xIn[OP_W-1], xIn}; mulB = {xIn[OP_W-1], xIn};
    end else begin
      mulA = (signMode == 2'b01) ? {1'b0, xIn} : {xIn[OP_W-1], xIn};
      mulB = (signMode == 2'b01 || signMode == 2'b10) ? {1'b0, yIn} : {yIn[OP_W-1], yIn};
    end
  end

  assign prod = mulA * mulB;
  assign prodExt = intMode ? {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod}
                           : {{(SUM_W-PROD_W-1){prod[PROD_W-1]}}, prod, 1'b0};

  assign selfExt  = stb.dstB ? {acc[1][ACC_W-1], acc[1]} : {acc[0][ACC_W-1], acc[0]};
  assign otherExt = stb.dstB ? {acc[0][ACC_W-1], acc[0]} : {acc[1][ACC_W-1], acc[1]};

  always_comb begin
    case (stb.src)
      SRC_PROD:  operand = prodExt;
      SRC_OTHER: operand = otherExt;
      SRC_SELF:  operand = selfExt;
      default:   operand = '0;
    endcase
    addend = stb.keepAcc ? selfExt : '0;
    sum    = stb.negate ? addend - operand : addend + operand;
  end

  assign satEnSel = stb.dstB ? satEnB : satEnA;
  assign hiLim    = satWide ? HI_WIDE : HI_NARROW;
  assign loLim    = satWide ? LO_WIDE : LO_NARROW;

  always_comb begin
    satHit = 1'b0;
    res    = sum;
    if (satEnSel && sum > hiLim) begin
      res = hiLim; satHit = 1'b1;
    end else if (satEnSel && sum < loLim) begin
      res = loLim; satHit = 1'b1;
    end
  end

  assign newVal = res[ACC_W-1:0];
  assign ovfNew = !((&newVal[ACC_W-1:NARROW_W-1]) || !(|newVal[ACC_W-1:NARROW_W-1]));

  for (genvar g = 0; g < 2; g++) begin : g_acc
    logic hit;
    assign hit = stb.wrEn && (stb.dstB == g[0]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc[g]     <= '0;
        ovfFlag[g] <= 1'b0;
        satFlag[g] <= 1'b0;
      end else begin
        if (hit) begin
          acc[g]     <= newVal;
          ovfFlag[g] <= ovfNew;
        end
        satFlag[g] <= (satFlag[g] && !clrSatAll) || (hit && satHit);
      end
    end
  end

  assign accA = acc[0];
  assign accB = acc[1];

  logic [ACC_W-1:0]       srcAcc;
  logic [OP_W-1:0]        lowHalf;
  logic                   bump;
  logic signed [QW-1:0]   rounded;

  assign srcAcc  = accSel ? acc[1] : acc[0];
  assign lowHalf = srcAcc[OP_W-1:0];
  assign bump    = roundConv ? lowHalf[OP_W-1]
                             : ((lowHalf > HALF) || (lowHalf == HALF && srcAcc[OP_W]));
  assign rounded = {srcAcc[ACC_W-1], srcAcc[ACC_W-1:OP_W]} + {{(QW-1){1'b0}}, bump};

  always_comb begin
    if (satEnStore && rounded > HI_STORE)      storeVal = HI_STORE[OP_W-1:0];
    else if (satEnStore && rounded < LO_STORE) storeVal = LO_STORE[OP_W-1:0];
    else                                       storeVal = rounded[OP_W-1:0];
  end
endmodule

// File: rtl/mac_engine.sv
module mac_engine
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic              accSel,
  input  logic [OP_W-1:0]   xIn,
  input  logic [OP_W-1:0]   yIn,
  input  logic              intMode,
  input  logic [1:0]        signMode,
  input  logic              roundConv,
  input  logic              satEnA,
  input  logic              satEnB,
  input  logic              satEnStore,
  input  logic              satWide,
  input  logic              clrSatAll,
  output logic [ACC_W-1:0]  accA,
  output logic [ACC_W-1:0]  accB,
  output logic [OP_W-1:0]   storeVal,
  output logic              ovfA,
  output logic              ovfB,
  output logic              satA,
  output logic              satB,
  output logic              ovfAny,
  output logic              satAny
);
  mac_strobe_t stb;
  logic [1:0] ovfFlag, satFlag;

  mac_ctrl u_ctrl (.opValid(opValid), .opCode(opCode), .accSel(accSel), .stb(stb));

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accSel(accSel), .xIn(xIn), .yIn(yIn),
    .intMode(intMode), .signMode(signMode), .roundConv(roundConv),
    .satEnA(satEnA), .satEnB(satEnB), .satEnStore(satEnStore), .satWide(satWide),
    .clrSatAll(clrSatAll), .accA(accA), .accB(accB), .storeVal(storeVal),
    .ovfFlag(ovfFlag), .satFlag(satFlag)
  );

  assign ovfA   = ovfFlag[0];
  assign ovfB   = ovfFlag[1];
  assign satA   = satFlag[0];
  assign satB   = satFlag[1];
  assign ovfAny = ovfFlag[0] | ovfFlag[1];
  assign satAny = satFlag[0] | satFlag[1];
endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [3:0]       opCode,
  input logic             accSel,
  input logic             satEnA,
  input logic             satWide,
  input logic             clrSatAll,
  input logic [ACC_W-1:0] accA,
  input logic [ACC_W-1:0] accB,
  input logic             ovfA,
  input logic             satA,
  input logic             satB
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(accA) && $stable(accB))); // R7
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && accSel) |=> $stable(accA)); // R7
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satA && !clrSatAll) |=> satA); // R9
  AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrSatAll && !opValid) |=> (!satA && !satB)); // R9
  AST_NARROW_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !accSel && satEnA && !satWide && opCode < 4'd12)
      |=> ((&accA[ACC_W-1:31]) || !(|accA[ACC_W-1:31]))); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && accSel && opCode == 4'd0) |=> (accB == '0)); // R4
  AST_OVF_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    !ovfA |-> ((&accA[ACC_W-1:31]) || !(|accA[ACC_W-1:31]))); // R10
endmodule

bind mac_engine mac_engine_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .accSel(accSel),
  .satEnA(satEnA), .satWide(satWide), .clrSatAll(clrSatAll),
  .accA(accA), .accB(accB), .ovfA(ovfA), .satA(satA), .satB(satB)
);

// File: tb/mac_engine_tb.sv
module mac_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic accSel = 1'b0;
  logic [15:0] xIn = '0, yIn = '0;
  logic intMode = 1'b0;
  logic [1:0] signMode = 2'b00;
  logic roundConv = 1'b1, satEnA = 1'b0, satEnB = 1'b0, satEnStore = 1'b0;
  logic satWide = 1'b0, clrSatAll = 1'b0;
  logic [39:0] accA, accB;
  logic [15:0] storeVal;
  logic ovfA, ovfB, satA, satB, ovfAny, satAny;

  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit finished = 0;

  longint mAcc [2];
  bit mOvf [2], mSat [2];

  always #5 clk = ~clk;

  mac_engine u_dut (.*);

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint ux(input logic [15:0] v);
    return longint'({48'd0, v});
  endfunction

  function automatic logic [15:0] expStore(input longint a);
    longint low, r, q;
    low = a & 64'hFFFF;
    if (roundConv) r = a + 64'sh8000;
    else if (low > 64'sh8000) r = a + 64'sh8000;
    else if (low == 64'sh8000 && ((a >>> 16) & 1) == 1) r = a + 64'sh8000;
    else r = a;
    q = r >>> 16;
    if (satEnStore && q > 32767) q = 32767;
    if (satEnStore && q < -32768) q = -32768;
    return q[15:0];
  endfunction

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (rstN) begin
      int d;
      longint self, other, p, a, b, v, hi;
      bit wr, en, hit;
      d = accSel ? 1 : 0;
      self = mAcc[d]; other = mAcc[1-d];
      wr = opValid && opCode < 12;
      hit = 0;
      a = 0; b = 0;
      if (opCode == 5 || opCode == 6) begin a = sx(xIn); b = a; end
      else if (opCode == 7 || opCode == 8) begin a = sx(xIn) - sx(yIn); b = a; end
      else begin
        a = (signMode == 2'b01) ? ux(xIn) : sx(xIn);
        b = (signMode == 2'b01 || signMode == 2'b10) ? ux(yIn) : sx(yIn);
      end
      p = a * b;
      if (!intMode) p = p * 2;
      case (opCode)
        0: v = 0;
        1, 5, 7: v = p;
        2: v = -p;
        3, 6, 8: v = self + p;
        4: v = self - p;
        9: v = self + other;
        10: v = self - other;
        default: v = -self;
      endcase
      en = accSel ? satEnB : satEnA;
      hi = satWide ? 64'sh7F_FFFF_FFFF : 64'sh7FFF_FFFF;
      if (en && v > hi) begin v = hi; hit = 1; end
      else if (en && v < -hi - 1) begin v = -hi - 1; hit = 1; end
      else v = (v <<< 24) >>> 24;
      for (int i = 0; i < 2; i++) if (clrSatAll) mSat[i] = 0;
      if (wr) begin
        mAcc[d] = v;
        mOvf[d] = (v > 64'sh7FFF_FFFF) || (v < -64'sh8000_0000);
        if (hit) mSat[d] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [39:0] eA, eB;
      logic [15:0] eS;
      eA = mAcc[0][39:0]; eB = mAcc[1][39:0];
      eS = expStore(mAcc[accSel ? 1 : 0]);
      compared++;
      if (accA !== eA || accB !== eB || storeVal !== eS || ovfA !== mOvf[0] || ovfB !== mOvf[1]
          || satA !== mSat[0] || satB !== mSat[1] || ovfAny !== (mOvf[0] | mOvf[1])
          || satAny !== (mSat[0] | mSat[1])) begin
        mismatched++;
        $display("FAIL %s: got A=%h B=%h st=%h ov=%b%b sat=%b%b any=%b%b exp A=%h B=%h st=%h ov=%b%b sat=%b%b",
                 curReq, accA, accB, storeVal, ovfA, ovfB, satA, satB, ovfAny, satAny,
                 eA, eB, eS, mOvf[0], mOvf[1], mSat[0], mSat[1]);
      end
    end
  end

  task automatic op(input logic [3:0] c, input logic sel, input logic [15:0] x, input logic [15:0] y);
    opValid = 1'b1; opCode = c; accSel = sel; xIn = x; yIn = y;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin mAcc[i] = 0; mOvf[i] = 0; mSat[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; idle(2);

    curReq = "R4";
    op(1, 0, 16'h4000, 16'h4000);
    op(3, 0, 16'h2000, 16'hC000);
    op(4, 0, 16'h1234, 16'h0567);
    op(2, 1, 16'h7FFF, 16'h8000);
    op(0, 1, 16'h1111, 16'h2222);

    curReq = "R2";
    signMode = 2'b01; op(1, 0, 16'hFFFF, 16'hFFFF);
    signMode = 2'b10; op(1, 1, 16'hFFFF, 16'hFFFF);
    signMode = 2'b11; op(1, 1, 16'hFFFF, 16'h8001);
    signMode = 2'b00;

    curReq = "R3";
    intMode = 1'b1; op(1, 0, 16'h0003, 16'hFFFB);
    intMode = 1'b0; op(1, 0, 16'h0003, 16'hFFFB);

    curReq = "R5";
    signMode = 2'b01;
    op(5, 0, 16'h8000, 16'h0000);
    op(6, 0, 16'h0100, 16'h0000);
    op(7, 1, 16'h7FFF, 16'h8000);
    op(8, 1, 16'h8000, 16'h7FFF);
    signMode = 2'b00;

    curReq = "R6";
    op(9, 0, 0, 0); op(10, 1, 0, 0); op(11, 1, 0, 0); op(11, 0, 0, 0);

    curReq = "R7";
    opValid = 1'b0; opCode = 4'd1; xIn = 16'h7777; yIn = 16'h7777; idle(2);
    for (int c = 12; c < 16; c++) op(4'(c), c[0], 16'h5555, 16'h3333);

    curReq = "R10";
    intMode = 1'b0; op(1, 0, 16'h8000, 16'h8000);
    op(0, 0, 0, 0);

    curReq = "R8";
    satEnA = 1'b1; satWide = 1'b0;
    op(1, 0, 16'h8000, 16'h8000);
    op(2, 0, 16'h8000, 16'h8000);
    satWide = 1'b1;
    op(1, 1, 16'h8000, 16'h8000);
    for (int i = 0; i < 300; i++) op(9, 0, 0, 0);
    satEnA = 1'b0; satEnB = 1'b0;
    op(1, 0, 16'h8000, 16'h8000);
    for (int i = 0; i < 300; i++) op(9, 0, 0, 0);

    curReq = "R9";
    clrSatAll = 1'b1; idle(1); clrSatAll = 1'b0; idle(1);
    satEnB = 1'b1; satWide = 1'b0;
    op(1, 1, 16'h8000, 16'h8000);
    clrSatAll = 1'b1; op(1, 1, 16'h8000, 16'h8000); clrSatAll = 1'b0;
    satEnB = 1'b0;

    curReq = "R11";
    intMode = 1'b1; signMode = 2'b01;
    for (int m = 1; m < 8; m++) begin
      op(1, 0, 16'(m), 16'h8000);
      roundConv = 1'b0; idle(1);
      roundConv = 1'b1; idle(1);
    end
    op(1, 1, 16'h0003, 16'h7FFF);
    roundConv = 1'b0; idle(1); roundConv = 1'b1;

    curReq = "R12";
    signMode = 2'b00; intMode = 1'b0; satEnA = 1'b0;
    op(1, 0, 16'h8000, 16'h8000);
    satEnStore = 1'b1; idle(1);
    op(11, 0, 0, 0); idle(1);
    satEnStore = 1'b0; idle(1);

    curReq = "R8";
    for (int i = 0; i < 400; i++) begin
      intMode = $urandom_range(0, 1); signMode = 2'($urandom_range(0, 3));
      roundConv = $urandom_range(0, 1); satEnA = $urandom_range(0, 1);
      satEnB = $urandom_range(0, 1); satEnStore = $urandom_range(0, 1);
      satWide = $urandom_range(0, 1); clrSatAll = ($urandom_range(0, 15) == 0);
      op(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
    end
    clrSatAll = 1'b0; idle(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: got no finish, exp finish before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule